// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance counter. Every cycle it receives a bundle of per-cycle occurrence counts, grouped into event groups of eight sub-event lanes each. A configuration word picks one group by an 8-bit event code and a set of its lanes by an 8-bit unit mask. The per-cycle total of the chosen lanes then passes through a set of qualifiers: a threshold with optional inversion, a rising-edge filter and a privilege filter. The result is added to a 40-bit accumulator.

Software loads the configuration word and can read it back. It can read and overwrite the counter value at any time. When the accumulator wraps, a sticky overflow flag is set, and an interrupt line follows that flag while interrupts are enabled.

The configuration word has this layout:

| Bits | Field |
|------|-------|
| 31:24 | threshold |
| 23:22 | spare, stored and read back |
| 21 | global enable |
| 20 | interrupt enable |
| 19 | invert |
| 18 | edge mode |
| 17 | kernel-level enable |
| 16 | user-level enable |
| 15:8 | unit mask |
| 7:0 | event code |

Top module: `qevt_counter`

## Requirements
- R1: After reset the counter, the overflow flag, the interrupt line and the configuration word all read zero.
- R2: Event code c below NUM_CODES selects group c. Lane l of group c sits at bits [(c*8+l)*CNT_W +: CNT_W] of the lane bus. Every lane whose unit-mask bit is set contributes to the per-cycle total. A zero unit mask selects lane 0 alone. An event code of NUM_CODES or above yields a total of zero.
- R3: With a threshold of zero and edge mode off, a qualifying cycle adds the full per-cycle total, which may exceed one.
- R4: With a non-zero threshold and invert clear, the counter adds one in a cycle whose total is greater than or equal to the threshold.
- R5: With a non-zero threshold and invert set, the counter adds one in a cycle whose total is below the threshold. With a threshold of zero, the invert bit has no effect.
- R6: In edge mode the counter adds one only in a cycle where the qualified condition is true and was false in the previous cycle. The remembered previous condition is false after reset and after any configuration write.
- R7: Privilege input value 0 counts only when the kernel-level enable is set. Values 1 to 3 count only when the user-level enable is set. With both enables clear, every level counts.
- R8: While the global enable is clear, the counter does not change unless software writes it.
- R9: A counter write loads the written value on the next cycle and overrides any increment in that cycle.
- R10: A carry out of bit 39 sets the overflow flag. The flag stays set until the clear input is pulsed. A wrap in the same cycle as a clear leaves the flag set.
- R11: The interrupt line is high exactly when the overflow flag is set and the interrupt enable is set.
- R12: A configuration write is read back on the next cycle, all 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_lanes_i | input | NUM_CODES*8*CNT_W | Per-cycle occurrence count of each sub-event lane |
| priv_i | input | 2 | Current privilege level, 0 is kernel |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_o | output | 32 | Configuration word readback |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | CTR_W | Counter write data |
| cnt_o | output | CTR_W | Counter value |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Overflow interrupt |

## Verification
A wrong lane pick, threshold compare or privilege decision shows up at cnt_o on the very next cycle, as an increment that differs from what the configuration implies. A stale edge-detector state shows up as one extra or one missing count right after a configuration write, or on the first cycle of a long true run. A bad carry or a bad flag-clear priority shows on ovf_o and irq_o one cycle after the wrap. The reference model compares all four outputs every cycle, so a fault is caught within one cycle of the stimulus that exposes it.

// File: rtl/qevt_pkg.sv
package qevt_pkg;

    localparam int LANES = 8;
    localparam int CFG_W = 32;

    typedef struct packed {
        logic [7:0] cmask;
        logic [1:0] spare;
        logic       enable;
        logic       int_en;
        logic       inv;
        logic       edge_md;
        logic       os_en;
        logic       usr_en;
        logic [7:0] umask;
        logic [7:0] code;
    } cfg_t;

    typedef struct packed {
        logic prev;
    } qual_st_t;

endpackage

// File: rtl/qevt_select.sv
module qevt_select #(
    parameter int NUM_CODES = 4,
    parameter int CNT_W     = 3,
    parameter int SUM_W     = 6
) (
    input  logic [NUM_CODES*qevt_pkg::LANES*CNT_W-1:0] lanes_i,
    input  logic [7:0]                                 code_i,
    input  logic [7:0]                                 umask_i,
    output logic [SUM_W-1:0]                           sum_o
);
    localparam int LN = qevt_pkg::LANES;

    logic [LN-1:0]    pick;
    logic [SUM_W-1:0] grp_sum [NUM_CODES];

    // a zero mask selects the base lane only
    assign pick = (umask_i == '0) ? LN'(1) : umask_i;

    for (genvar c = 0; c < NUM_CODES; c++) begin : g_grp
        logic [SUM_W-1:0] acc;
        always_comb begin
            acc = '0;
            for (int l = 0; l < LN; l++) begin
                if (pick[l]) begin
                    acc = acc + SUM_W'(lanes_i[(c*LN+l)*CNT_W +: CNT_W]);
                end
            end
        end
        assign grp_sum[c] = acc;
    end

    always_comb begin
        sum_o = '0;
        for (int c = 0; c < NUM_CODES; c++) begin
            if (code_i == 8'(c)) begin
                sum_o = grp_sum[c];
            end
        end
    end

endmodule

// File: rtl/qevt_qualify.sv
module qevt_qualify #(
    parameter int SUM_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SUM_W-1:0] sum_i,
    input  logic [7:0]       cmask_i,
    input  logic             inv_i,
    input  logic             edge_md_i,
    input  logic             os_en_i,
    input  logic             usr_en_i,
    input  logic             enable_i,
    input  logic [1:0]       priv_i,
    input  logic             clr_prev_i,
    output logic [SUM_W-1:0] amt_o
);
    import qevt_pkg::*;

    qual_st_t   st_d, st_q;
    logic [15:0] sum_ext, cm_ext;
    logic        thr, priv_ok, hit;

    always_comb begin
        sum_ext = 16'(sum_i);
        cm_ext  = 16'(cmask_i);
        if (cmask_i == '0) begin
            thr = (sum_i != '0);
        end else if (inv_i) begin
            thr = (sum_ext < cm_ext);
        end else begin
            thr = (sum_ext >= cm_ext);
        end
        priv_ok = (!os_en_i && !usr_en_i)
                || (os_en_i && priv_i == 2'd0)
                || (usr_en_i && priv_i != 2'd0);
        hit = enable_i && thr && priv_ok;

        if (edge_md_i) begin
            amt_o = (hit && !st_q.prev) ? SUM_W'(1) : '0;
        end else if (hit) begin
            amt_o = (cmask_i == '0) ? sum_i : SUM_W'(1);
        end else begin
            amt_o = '0;
        end

        st_d      = st_q;
        st_d.prev = clr_prev_i ? 1'b0 : hit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_md_i && amt_o != '0 && !clr_prev_i) |=> (amt_o == '0)); // R6
    AST_THRESH_UNIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmask_i != '0) |-> (amt_o <= SUM_W'(1))); // R4
    AST_PRIV_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (os_en_i && !usr_en_i && priv_i != 2'd0) |-> (amt_o == '0)); // R7

endmodule

// File: rtl/qevt_accum.sv
module qevt_accum #(
    parameter int CTR_W = 40,
    parameter int SUM_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SUM_W-1:0] amt_i,
    input  logic             cnt_we_i,
    input  logic [CTR_W-1:0] cnt_wdata_i,
    input  logic             ovf_clr_i,
    output logic [CTR_W-1:0] cnt_o,
    output logic             ovf_o
);
    typedef struct packed {
        logic [CTR_W-1:0] cnt;
        logic             ovf;
    } acc_st_t;

    acc_st_t        st_d, st_q;
    logic [CTR_W:0] tot;
    logic           wrap;

    always_comb begin
        tot  = {1'b0, st_q.cnt} + {{(CTR_W+1-SUM_W){1'b0}}, amt_i};
        st_d = st_q;
        wrap = 1'b0;
        if (cnt_we_i) begin
            st_d.cnt = cnt_wdata_i;
        end else begin
            st_d.cnt = tot[CTR_W-1:0];
            wrap     = tot[CTR_W];
        end
        st_d.ovf = wrap | (st_q.ovf & ~ovf_clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;

    AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_we_i |=> (cnt_o == $past(cnt_wdata_i))); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && !ovf_clr_i) |=> ovf_o); // R10
    AST_FLAG_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovf_o) |-> (cnt_o < $past(cnt_o))); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cnt_we_i && amt_i == '0) |=> $stable(cnt_o)); // R3

endmodule

// File: rtl/qevt_counter.sv
module qevt_counter #(
    parameter int NUM_CODES = 4,
    parameter int CNT_W     = 3,
    parameter int CTR_W     = 40
) (
    input  logic                                       clk_i,
    input  logic                                       rst_ni,
    input  logic [NUM_CODES*qevt_pkg::LANES*CNT_W-1:0] evt_lanes_i,
    input  logic [1:0]                                 priv_i,
    input  logic                                       cfg_we_i,
    input  logic [31:0]                                cfg_wdata_i,
    output logic [31:0]                                cfg_o,
    input  logic                                       cnt_we_i,
    input  logic [CTR_W-1:0]                           cnt_wdata_i,
    output logic [CTR_W-1:0]                           cnt_o,
    input  logic                                       ovf_clr_i,
    output logic                                       ovf_o,
    output logic                                       irq_o
);
    import qevt_pkg::*;

    localparam int SUM_W = CNT_W + $clog2(LANES);

    cfg_t             cfg_d, cfg_q;
    logic [SUM_W-1:0] sel_sum, amt;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we_i) cfg_d = cfg_t'(cfg_wdata_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    qevt_select #(.NUM_CODES(NUM_CODES), .CNT_W(CNT_W), .SUM_W(SUM_W)) sel_i (
        .lanes_i (evt_lanes_i),
        .code_i  (cfg_q.code),
        .umask_i (cfg_q.umask),
        .sum_o   (sel_sum)
    );

    qevt_qualify #(.SUM_W(SUM_W)) qual_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sum_i      (sel_sum),
        .cmask_i    (cfg_q.cmask),
        .inv_i      (cfg_q.inv),
        .edge_md_i  (cfg_q.edge_md),
        .os_en_i    (cfg_q.os_en),
        .usr_en_i   (cfg_q.usr_en),
        .enable_i   (cfg_q.enable),
        .priv_i     (priv_i),
        .clr_prev_i (cfg_we_i),
        .amt_o      (amt)
    );

    qevt_accum #(.CTR_W(CTR_W), .SUM_W(SUM_W)) acc_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .amt_i       (amt),
        .cnt_we_i    (cnt_we_i),
        .cnt_wdata_i (cnt_wdata_i),
        .ovf_clr_i   (ovf_clr_i),
        .cnt_o       (cnt_o),
        .ovf_o       (ovf_o)
    );

    assign cfg_o = cfg_q;
    assign irq_o = ovf_o & cfg_q.int_en;

    AST_IRQ_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ovf_o); // R11
    AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_q.enable && !cnt_we_i) |=> $stable(cnt_o)); // R8
    AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_we_i |=> (cfg_o == $past(cfg_wdata_i))); // R12

endmodule

// File: tb/qevt_counter_tb_top.sv
`timescale 1ns/1ps
module qevt_counter_tb_top;

    localparam int NC    = 4;
    localparam int CW    = 3;
    localparam int CTR   = 40;
    localparam int LBITS = NC*8*CW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LBITS-1:0] lanes = '0;
    logic [1:0]       priv = '0;
    logic             cfg_we = 1'b0;
    logic [31:0]      cfg_wd = '0;
    logic [31:0]      cfg_rd;
    logic             cnt_we = 1'b0;
    logic [CTR-1:0]   cnt_wd = '0;
    logic [CTR-1:0]   cnt_rd;
    logic             clr = 1'b0;
    logic             ovf, irq;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // reference state, as it should read after the latest clock edge
    longint unsigned m_cnt = 0;
    bit              m_ovf = 0;
    bit [31:0]       m_cfg = 0;
    bit              m_prev = 0;

    always #2.5 clk = ~clk;

    qevt_counter #(.NUM_CODES(NC), .CNT_W(CW), .CTR_W(CTR)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .evt_lanes_i(lanes), .priv_i(priv),
        .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cfg_o(cfg_rd),
        .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wd), .cnt_o(cnt_rd),
        .ovf_clr_i(clr), .ovf_o(ovf), .irq_o(irq)
    );

    function automatic bit [31:0] mk_cfg(int code, int umask, int cmask, bit inv,
                                         bit edg, bit os, bit usr, bit en, bit ie);
        return {8'(cmask), 2'b00, en, ie, inv, edg, os, usr, 8'(umask), 8'(code)};
    endfunction

    task automatic compare(string tag);
        n_chk++;
        if (cnt_rd !== m_cnt[CTR-1:0]) begin
            n_fail++;
            $display("FAIL %s counter actual=%h expected=%h", tag, cnt_rd, m_cnt[CTR-1:0]);
        end
        n_chk++;
        if (ovf !== m_ovf) begin
            n_fail++;
            $display("FAIL R10 overflow actual=%0b expected=%0b", ovf, m_ovf);
        end
        n_chk++;
        if (irq !== (m_ovf & m_cfg[20])) begin
            n_fail++;
            $display("FAIL R11 irq actual=%0b expected=%0b", irq, m_ovf & m_cfg[20]);
        end
        n_chk++;
        if (cfg_rd !== m_cfg) begin
            n_fail++;
            $display("FAIL R12 cfg actual=%h expected=%h", cfg_rd, m_cfg);
        end
    endtask

    // advance the reference by one clock edge using the inputs now driven
    task automatic model_step();
        int  code  = int'(m_cfg[7:0]);
        int  umask = int'(m_cfg[15:8]);
        int  cm    = int'(m_cfg[31:24]);
        int  sum   = 0;
        int  amt   = 0;
        bit  thr, pok, hit;
        bit  os  = m_cfg[17];
        bit  usr = m_cfg[16];
        if (umask == 0) umask = 1;
        if (code < NC) begin
            for (int l = 0; l < 8; l++) begin
                if (umask[l]) sum += int'(lanes[(code*8+l)*CW +: CW]);
            end
        end
        if (cm == 0)         thr = (sum != 0);
        else if (m_cfg[19])  thr = (sum < cm);
        else                 thr = (sum >= cm);
        if (!os && !usr)     pok = 1;
        else                 pok = (os && priv == 0) || (usr && priv != 0);
        hit = m_cfg[21] && thr && pok;
        if (m_cfg[18])       amt = (hit && !m_prev) ? 1 : 0;
        else if (hit)        amt = (cm == 0) ? sum : 1;
        m_prev = cfg_we ? 1'b0 : hit;
        if (cnt_we) begin
            m_cnt = longint'(cnt_wd);
            m_ovf = m_ovf & ~clr;
        end else begin
            m_cnt = m_cnt + longint'(amt);
            if (m_cnt >= (64'd1 << CTR)) begin
                m_cnt = m_cnt - (64'd1 << CTR);
                m_ovf = 1;
            end else begin
                m_ovf = m_ovf & ~clr;
            end
        end
        if (cfg_we) m_cfg = cfg_wd;
    endtask

    task automatic cycle(bit cw, bit [31:0] cwd, bit nw, bit [CTR-1:0] nwd,
                         bit cl, int lmax, string tag);
        @(negedge clk);
        compare(tag);
        for (int i = 0; i < NC*8; i++) lanes[i*CW +: CW] = CW'($urandom_range(0, lmax));
        priv   = 2'($urandom_range(0, 3));
        cfg_we = cw;  cfg_wd = cwd;
        cnt_we = nw;  cnt_wd = nwd;
        clr    = cl;
        model_step();
    endtask

    task automatic run(int n, int lmax, string tag);
        for (int k = 0; k < n; k++) cycle(0, 0, 0, 0, 0, lmax, tag);
    endtask

    task automatic set_cfg(bit [31:0] w, string tag);
        cycle(1, w, 0, 0, 0, 3, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cycle(0, 0, 0, 0, 0, 3, "R1");
        run(5, 3, "R1");
        // R3 + R2: full sum of lanes 2 and 3 of group 1
        set_cfg(mk_cfg(1, 8'h0C, 0, 0, 0, 0, 0, 1, 0), "R3");
        run(200, 3, "R3");
        // R2: zero mask picks lane 0
        set_cfg(mk_cfg(2, 0, 0, 0, 0, 0, 0, 1, 0), "R2");
        run(100, 7, "R2");
        // R2: unknown event code counts nothing
        set_cfg(mk_cfg(9, 8'hFF, 0, 0, 0, 0, 0, 1, 0), "R2");
        run(50, 7, "R2");
        // R4: threshold
        set_cfg(mk_cfg(0, 8'hFF, 4, 0, 0, 0, 0, 1, 0), "R4");
        run(200, 1, "R4");
        // R5: inverted threshold, then invert with zero threshold
        set_cfg(mk_cfg(0, 8'hFF, 4, 1, 0, 0, 0, 1, 0), "R5");
        run(200, 1, "R5");
        set_cfg(mk_cfg(3, 8'h81, 0, 1, 0, 0, 0, 1, 0), "R5");
        run(200, 2, "R5");
        // R6: edge with threshold, rewrite config mid-run
        set_cfg(mk_cfg(0, 8'h0F, 3, 0, 1, 0, 0, 1, 0), "R6");
        run(150, 1, "R6");
        set_cfg(mk_cfg(0, 8'h0F, 3, 0, 1, 0, 0, 1, 0), "R6");
        run(150, 1, "R6");
        set_cfg(mk_cfg(1, 8'h01, 0, 0, 1, 0, 0, 1, 0), "R6");
        run(200, 1, "R6");
        // R7: kernel only, user only, both
        set_cfg(mk_cfg(0, 8'hF0, 0, 0, 0, 1, 0, 1, 0), "R7");
        run(150, 3, "R7");
        set_cfg(mk_cfg(0, 8'hF0, 0, 0, 0, 0, 1, 1, 0), "R7");
        run(150, 3, "R7");
        set_cfg(mk_cfg(0, 8'hF0, 2, 0, 0, 1, 1, 1, 0), "R7");
        run(100, 3, "R7");
        // R8: global enable clear
        set_cfg(mk_cfg(0, 8'hFF, 0, 0, 0, 0, 0, 0, 1), "R8");
        run(100, 7, "R8");
        // R9: writes interleaved with counting
        set_cfg(mk_cfg(2, 8'hFF, 0, 0, 0, 0, 0, 1, 0), "R9");
        for (int k = 0; k < 60; k++) begin
            cycle(0, 0, 1, CTR'({$urandom(), $urandom()}), 0, 7, "R9");
            run(3, 7, "R9");
        end
        // R10 / R11: wrap with interrupt enabled, random clears
        set_cfg(mk_cfg(0, 8'hFF, 0, 0, 0, 0, 0, 1, 1), "R11");
        for (int k = 0; k < 20; k++) begin
            cycle(0, 0, 1, {CTR{1'b1}} - CTR'(40), 0, 3, "R10");
            for (int j = 0; j < 12; j++)
                cycle(0, 0, 0, 0, ($urandom_range(0, 5) == 0), 3, "R10");
            cycle(0, 0, 0, 0, 1, 0, "R10");
        end
        // R10: wrap in the same cycle as a clear keeps the flag
        cycle(0, 0, 1, {CTR{1'b1}}, 0, 7, "R10");
        cycle(0, 0, 0, 0, 1, 7, "R10");
        run(3, 0, "R10");
        // R11: interrupt disabled while flag set
        set_cfg(mk_cfg(0, 8'hFF, 0, 0, 0, 0, 0, 1, 0), "R11");
        run(10, 1, "R11");
        cycle(0, 0, 0, 0, 1, 0, "R10");
        run(5, 0, "R10");
        @(negedge clk);
        compare("R9");
        finished = 1;
        summary();
        $finish;
    end

endmodule